// File: doc/BRIEF.md
# Asymmetric Turn-On Delay Filter

This block filters one binary signal so that a transition to 1 is passed on only after the input has stayed high for a programmable number of sample ticks. A transition to 0 is passed on at the next sample with no delay. A low sample also discards any turn-on delay that is still counting, so a short high pulse never reaches the output. Time is measured in samples. A sample is a clock cycle in which the sample-enable strobe is high, so the delay in seconds is the sample count divided by the sample rate.

The delay length is a run-time input and is read at the moment a rise is seen. Legal lengths run from 0 to a fixed ceiling of 100 samples. A rise that is presented with a longer length raises an error flag instead of arming the delay. The output then stays low until the input falls.

Top module: `tdf_filter`

## Requirements
- R1: One clock edge with `rst_n` low leaves `dout` at 0 and `len_err` at 0. The first high sample after reset counts as a rise.
- R2: State changes only on clock edges where `smp_en` is 1. On other edges `dout`, `len_err` and the progress of any pending delay hold their values.
- R3: A rise is a sample with `din` = 1 whose previous sample had `din` = 0. For a legal length L of 1 or more, `dout` becomes 1 after the clock edge of the sample on which `din` has been 1 for L+1 consecutive samples, counting the rise sample.
- R4: A length of 0 at the rise makes `dout` 1 after the edge of the rise sample itself.
- R5: Any sample with `din` = 0 drives `dout` to 0 after that edge and drops a pending delay. The next rise starts counting afresh.
- R6: If `din` stays high for L samples or fewer, counting the rise sample, `dout` never becomes 1.
- R7: A length above 100 at a rise sets `len_err` to 1 after that edge and keeps `dout` at 0 while `din` stays high. The next sample with `din` = 0 clears `len_err`. A length of exactly 100 is legal.
- R8: The length is captured only at the rise. Changes on `dly_len` while the input stays high have no effect on the delay or on `len_err`.
- R9: `dout` and `len_err` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_en | input | 1 | Sample-enable strobe, one sample per high cycle |
| din | input | 1 | Binary input to be filtered |
| dly_len | input | LEN_W (8) | Turn-on delay in samples, read at a rise |
| dout | output | 1 | Filtered output |
| len_err | output | 1 | Delay length at the last rise was out of range |

## Verification
The hardest situations to reach are a length change in the middle of a count and a pulse that ends exactly one sample short of the delay. Both depend on the length and the input moving on precise samples relative to the rise. The bench steps the input one sample at a time. It changes `dly_len` a few samples after the rise, and it issues pulses of L, L+1 and fewer samples, sometimes with the strobe held low in between so that idle cycles fall inside a count. A behavioural reference model predicts the output on every clock, so each of these stimuli is checked cycle by cycle.

// File: rtl/tdf_pkg.sv
// Package: shared types for the turn-on delay filter.
// Assumes: a four-state controller is enough to cover idle, counting,
// passing and faulted conditions.
package tdf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PASS  = 2'd2,
        ST_FAULT = 2'd3
    } tdf_state_e;
endpackage

// File: rtl/tdf_edge_detect.sv
// Module: tdf_edge_detect
// Remembers the input value taken at the last sample and flags rise and
// low samples. Assumes the input is stable around the sampling clock edge.
module tdf_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic din,
    output logic rise,
    output logic low_smp
);
    logic last_q;

    // Capture the input on every sample; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= 1'b0;
        else if (smp_en)
            last_q <= din;
    end

    // Decode the sample type from the current and remembered levels.
    always_comb begin
        rise    = smp_en && din && !last_q;
        low_smp = smp_en && !din;
    end
endmodule

// File: rtl/tdf_len_check.sv
// Module: tdf_len_check
// Classifies a delay length as legal or zero. Assumes MAX_LEN fits in LEN_W.
module tdf_len_check #(
    parameter int LEN_W   = 8,
    parameter int MAX_LEN = 100
) (
    input  logic [LEN_W-1:0] len,
    output logic             legal,
    output logic             zero
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

    // Compare against the fixed ceiling and against zero.
    always_comb begin
        legal = (len <= LIMIT);
        zero  = (len == '0);
    end
endmodule

// File: rtl/tdf_delay_counter.sv
// Module: tdf_delay_counter
// Holds a captured target and counts samples after a rise. It flags the
// step that reaches the target. Assumes load and step are never both high.
module tdf_delay_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] tgt_q;
    logic [W-1:0] cnt_inc;

    // Capture the target on load, advance the count on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            tgt_q <= load_val;
        end else if (step) begin
            cnt_q <= cnt_inc;
        end
    end

    // Flag the step whose incremented count meets the target.
    always_comb begin
        cnt_inc = cnt_q + W'(1);
        expire  = step && (cnt_inc == tgt_q);
    end
endmodule

// File: rtl/tdf_filter.sv
// Module: tdf_filter (top)
// Turn-on delay filter. A rise is passed on after a run-time number of
// samples, and a low sample is passed on at once. The length is range
// checked at the rise. Assumes a single-bit input and a synchronous
// active-low reset.
module tdf_filter #(
    parameter int LEN_W   = 8,
    parameter int MAX_LEN = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             din,
    input  logic [LEN_W-1:0] dly_len,
    output logic             dout,
    output logic             len_err
);
    import tdf_pkg::*;

    tdf_state_e state_q;
    tdf_state_e state_d;
    logic       rise;
    logic       low_smp;
    logic       legal;
    logic       zero;
    logic       load;
    logic       step;
    logic       expire;

    tdf_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .din    (din),
        .rise   (rise),
        .low_smp(low_smp)
    );

    tdf_len_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk_len (
        .len  (dly_len),
        .legal(legal),
        .zero (zero)
    );

    tdf_delay_counter #(.W(LEN_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .load_val(dly_len),
        .expire  (expire)
    );

    // Counter controls: capture at a legal rise, step on high samples while counting.
    always_comb begin
        load = rise && legal && (state_q == ST_IDLE);
        step = smp_en && din && (state_q == ST_COUNT);
    end

    // Next-state selection for the filter controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rise) begin
                    if (!legal)
                        state_d = ST_FAULT;
                    else if (zero)
                        state_d = ST_PASS;
                    else
                        state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (low_smp)
                    state_d = ST_IDLE;
                else if (expire)
                    state_d = ST_PASS;
            end
            ST_PASS, ST_FAULT: begin
                if (low_smp)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        dout    = (state_q == ST_PASS);
        len_err = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/tdf_filter_chk.sv
// Module: tdf_filter_chk
// Port-level properties for tdf_filter, attached with bind.
module tdf_filter_chk #(
    parameter int LEN_W   = 8,
    parameter int MAX_LEN = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_en,
    input logic             din,
    input logic [LEN_W-1:0] dly_len,
    input logic             dout,
    input logic             len_err
);
    logic prev_s;

    // Track the last sampled input independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_s <= 1'b0;
        else if (smp_en)
            prev_s <= din;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !dout && !len_err);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(dout) && $stable(len_err));

    // R4
    zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en && din && !prev_s && dly_len == '0 |=> dout);

    // R5
    fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en && !din |=> !dout && !len_err);

    // R7
    range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en && din && !prev_s && dly_len > LEN_W'(MAX_LEN) |=> len_err && !dout);

    // R3
    rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout) |-> $past(din) && $past(smp_en));

    // R9
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout && len_err));
endmodule

bind tdf_filter tdf_filter_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_tdf_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (smp_en),
    .din    (din),
    .dly_len(dly_len),
    .dout   (dout),
    .len_err(len_err)
);

// File: tb/tdf_filter_bench.sv
`timescale 1ns/1ps
module tdf_filter_bench;
    localparam int LEN_W = 8;
    localparam int MAX_LEN = 100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_en = 1'b0;
    logic             din = 1'b0;
    logic [LEN_W-1:0] dly_len = '0;
    logic             dout;
    logic             len_err;

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // reference model state
    int m_run = 0;
    int m_lat = 0;
    bit m_out = 1'b0;
    bit m_err = 1'b0;

    always #4 clk = ~clk;

    tdf_filter #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_tdf_filter (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .din(din),
        .dly_len(dly_len), .dout(dout), .len_err(len_err)
    );

    // Behavioural model: length of the current high run against the captured length.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_lat = 0; m_out = 0; m_err = 0;
        end else if (smp_en) begin
            if (!din) begin
                m_run = 0; m_out = 0; m_err = 0;
            end else begin
                if (m_run == 0) begin
                    m_lat = int'(dly_len);
                    m_err = (int'(dly_len) > MAX_LEN);
                end
                if (m_run < 100000) m_run = m_run + 1;
                m_out = !m_err && (m_run > m_lat);
            end
        end
    end

    // Compare outputs against the model midway between edges.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (dout !== m_out || len_err !== m_err) begin
                failures++;
                $display("FAIL %s: dout=%b len_err=%b expected dout=%b len_err=%b at %0t",
                         tag, dout, len_err, m_out, m_err, $time);
            end
        end
    end

    task automatic step(input bit v, input int len, input bit en);
        @(negedge clk);
        din = v; dly_len = LEN_W'(len); smp_en = en;
    endtask

    task automatic hold(input bit v, input int len, input int n);
        for (int i = 0; i < n; i++) step(v, len, 1'b1);
    endtask

    initial begin
        // R1 reset state
        tag = "R1";
        din = 1'b1; smp_en = 1'b1; dly_len = 8'd0;
        repeat (3) @(negedge clk);
        checks++;
        if (dout !== 1'b0 || len_err !== 1'b0) begin
            failures++;
            $display("FAIL R1: dout=%b len_err=%b expected 0 0", dout, len_err);
        end
        step(1'b0, 0, 1'b1); rst_n = 1'b1;
        hold(1'b0, 0, 2);
        // R1: high right after reset is a rise
        hold(1'b1, 2, 5); hold(1'b0, 2, 2);

        tag = "R3"; hold(1'b1, 5, 12); hold(1'b0, 5, 3);
        tag = "R3_len1"; hold(1'b1, 1, 4); hold(1'b0, 1, 2);

        tag = "R2";
        for (int i = 0; i < 16; i++) step(1'b1, 4, i[0]);
        for (int i = 0; i < 4; i++) step(1'b0, 4, i[0]);
        step(1'b1, 3, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, 3, 1'b0);
        hold(1'b1, 3, 5); hold(1'b0, 3, 2);

        tag = "R4"; hold(1'b1, 0, 4); hold(1'b0, 0, 2);
        step(1'b1, 0, 1'b1); hold(1'b0, 0, 2);

        tag = "R6";
        hold(1'b1, 6, 4); hold(1'b0, 6, 2);
        hold(1'b1, 6, 6); hold(1'b0, 6, 2);
        hold(1'b1, 6, 7); hold(1'b0, 6, 2);

        tag = "R5";
        hold(1'b1, 3, 2); hold(1'b0, 3, 1); hold(1'b1, 3, 5);
        hold(1'b0, 3, 1); hold(1'b1, 3, 2); hold(1'b0, 3, 2);

        tag = "R7";
        hold(1'b1, 101, 6); hold(1'b0, 101, 2);
        hold(1'b1, 255, 3); hold(1'b0, 0, 1);
        hold(1'b1, 100, 103); hold(1'b0, 100, 2);

        tag = "R8";
        hold(1'b1, 8, 2); hold(1'b1, 1, 10); hold(1'b0, 1, 2);
        hold(1'b1, 200, 1); hold(1'b1, 0, 4); hold(1'b0, 0, 2);
        hold(1'b1, 2, 1); hold(1'b1, 200, 5); hold(1'b0, 0, 2);

        tag = "R9";
        hold(1'b1, 150, 3); hold(1'b0, 0, 1); hold(1'b1, 0, 3); hold(1'b0, 0, 2);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule